// File: doc/BRIEF.md
# Block Write Packetizer with Final Acknowledgement Check

This block sends the payload of a block write over a byte-wide serial link once the write command has been accepted elsewhere. It pulls payload bytes from a valid/ready stream and cuts the block into packets whose size is a power of two. Each packet goes out as a tag byte, then its payload bytes, then an optional 16-bit checksum.

No acknowledgement is awaited between packets, and anything the link returns while packets are going out is discarded. After the final packet the block clocks four more bytes in. It then looks in that window for the acknowledgement of the last packet, which may come after a stale acknowledgement of the packet before it. The outcome is reported as a one-cycle done pulse with a status code.

Every link transfer is a full-duplex byte exchange. The block raises `xfer_req` with `xfer_out`. The exchange completes in the cycle in which `xfer_ack` is high, and `xfer_in` carries the received byte in that cycle.

Top module: `bwp_block_writer`

## Requirements
- R1: After reset `done`, `xfer_req` and `src_ready` are low.
- R2: The packet size is 2^(8+c) bytes, where c is `size_code`; codes above 5 act as 5 (8192 bytes). Every packet but the last has the full size, and the last carries the remainder.
- R3: Each packet starts with a tag byte: 0xF1 for the first packet, 0xF2 for an inner packet, 0xF3 for the last. A block that fits in one packet is tagged 0xF3.
- R4: With `crc_en` high, each packet's payload is followed by a CRC-16 (polynomial 0x1021, seed 0xFFFF, MSB-first), high byte first. With `crc_en` low, no checksum bytes are sent.
- R5: Packets follow one another with no response exchange between them. Bytes received during packets are ignored, even when they look like acknowledgements. After the last packet exactly four exchanges follow, each sending 0x00.
- R6: A payload byte is taken only in a cycle where `src_valid`, `src_ready` and an exchange coincide. Source stalls and link stalls delay the byte stream but do not change it.
- R7: The four received bytes are indexed 0 to 3 in arrival order. Indices 2, 1 and 0 are searched in that order, and the first byte found with upper nibble 0xC is taken as the acknowledgement. An earlier stale acknowledgement is therefore passed over.
- R8: The status is ok (0) when the chosen byte has lower nibble 0x3 and the byte after it is 0x00. Any other value gives response error (2).
- R9: When none of indices 0 to 2 has upper nibble 0xC, the status is missing response (1). A start nibble at index 3 is not considered.
- R10: `done` is high for exactly one cycle, the cycle after the fourth window exchange, with `status` valid in that cycle. A `start` with `total_len` equal to 0 is ignored: no exchange and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block transfer (sampled when idle) |
| total_len | input | LEN_W | Block length in bytes |
| size_code | input | CODE_W | Packet size code, size = 2^(8+code) |
| crc_en | input | 1 | Append CRC-16 to each packet |
| src_data | input | 8 | Payload byte |
| src_valid | input | 1 | Payload byte available |
| src_ready | output | 1 | Payload byte taken this cycle |
| xfer_req | output | 1 | Link exchange requested |
| xfer_out | output | 8 | Byte to send |
| xfer_ack | input | 1 | Exchange completes this cycle |
| xfer_in | input | 8 | Byte received in the completing exchange |
| done | output | 1 | Transfer finished (one cycle) |
| status | output | 2 | 0 ok, 1 missing response, 2 response error |

## Verification
A wrong packet count or a wrong remaining count shows at the link port within one packet. It appears as a tag in the wrong position, a packet of the wrong length, or the four window exchanges starting too early or too late, and it is caught because the full sent stream is compared byte by byte. A corrupted checksum register shows in the two bytes after the packet it belongs to. A wrong window index or scan order shows only in `status` during the single done cycle. For that reason the response windows are built so that each scan position and each stale-reply arrangement gives a different expected status.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_NO_RSP  = 2'd1,
      ST_RSP_ERR = 2'd2
   } bwp_status_e;

   typedef enum logic [2:0] {
      S_IDLE, S_TAG, S_DATA, S_CRC_HI, S_CRC_LO, S_RSP, S_DONE
   } bwp_state_e;

   localparam logic [7:0]  TAG_FIRST = 8'hF1;
   localparam logic [7:0]  TAG_INNER = 8'hF2;
   localparam logic [7:0]  TAG_LAST  = 8'hF3;
   localparam logic [3:0]  RSP_START = 4'hC;
   localparam logic [3:0]  RSP_LAST  = 4'h3;
   localparam int          RSP_WIN   = 4;
   localparam logic [15:0] CRC_SEED  = 16'hFFFF;
   localparam logic [15:0] CRC_POLY  = 16'h1021;
endpackage

// File: rtl/bwp_sizer.sv
module bwp_sizer #(
   parameter int LEN_W   = 16,
   parameter int CODE_W  = 3,
   parameter int MIN_LOG = 8,
   parameter int MAX_LOG = 13
) (
   input  logic [LEN_W-1:0]  remaining,
   input  logic [CODE_W-1:0] size_code,
   output logic [LEN_W-1:0]  pkt_len,
   output logic              is_last
);
   localparam int SPAN = MAX_LOG - MIN_LOG;

   if (LEN_W <= MAX_LOG) begin : g_len_chk
      $error("LEN_W must exceed MAX_LOG");
   end
   if (SPAN < 0 || SPAN >= (1 << CODE_W)) begin : g_code_chk
      $error("size code field cannot span the packet size range");
   end

   logic [CODE_W-1:0] code_eff;
   logic [LEN_W-1:0]  pkt_max;

   always_comb begin
      code_eff = (size_code > CODE_W'(SPAN)) ? CODE_W'(SPAN) : size_code;
      pkt_max  = ({{(LEN_W-1){1'b0}}, 1'b1} << MIN_LOG) << code_eff;
      is_last  = (remaining <= pkt_max);
      pkt_len  = is_last ? remaining : pkt_max;
   end
endmodule

// File: rtl/bwp_crc16.sv
module bwp_crc16
   import bwp_pkg::*;
#(
   parameter int HAS_CRC = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] d);
      logic [15:0] c;
      logic        fb;
      c = c_in;
      for (int i = 7; i >= 0; i--) begin
         fb = c[15] ^ d[i];
         c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
      end
      return c;
   endfunction

   if (HAS_CRC != 0) begin : g_crc
      logic [15:0] crc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    crc_q <= CRC_SEED;
         else if (init) crc_q <= CRC_SEED;
         else if (upd)  crc_q <= crc_step(crc_q, din);
      end
      assign crc = crc_q;
   end else begin : g_no_crc
      assign crc = 16'h0000;
   end
endmodule

// File: rtl/bwp_rsp_scan.sv
module bwp_rsp_scan
   import bwp_pkg::*;
(
   input  logic [RSP_WIN-1:0][7:0] win,
   output logic [1:0]              status
);
   localparam int IDX_W = $clog2(RSP_WIN);

   logic             found;
   logic [IDX_W-1:0] idx;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = RSP_WIN - 2; i >= 0; i--) begin
         if (!found && win[i][7:4] == RSP_START) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
      if (!found)
         status = ST_NO_RSP;
      else if (win[idx][3:0] == RSP_LAST && win[idx + IDX_W'(1)] == 8'h00)
         status = ST_OK;
      else
         status = ST_RSP_ERR;
   end
endmodule

// File: rtl/bwp_block_writer.sv
module bwp_block_writer
   import bwp_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int CODE_W  = 3,
   parameter int MIN_LOG = 8,
   parameter int MAX_LOG = 13,
   parameter int HAS_CRC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  total_len,
   input  logic [CODE_W-1:0] size_code,
   input  logic              crc_en,
   input  logic [7:0]        src_data,
   input  logic              src_valid,
   output logic              src_ready,
   output logic              xfer_req,
   output logic [7:0]        xfer_out,
   input  logic              xfer_ack,
   input  logic [7:0]        xfer_in,
   output logic              done,
   output logic [1:0]        status
);
   localparam int   WIDX_W  = $clog2(RSP_WIN);
   localparam logic CRC_BIT = (HAS_CRC != 0);

   bwp_state_e               state;
   logic [LEN_W-1:0]         remaining, cnt, pkt_len;
   logic [CODE_W-1:0]        code_q;
   logic                     first_q, last_q, crc_on_q, is_last, xchg;
   logic [WIDX_W-1:0]        widx;
   logic [RSP_WIN-1:0][7:0]  win;
   logic [15:0]              crc;
   logic [1:0]               scan_status;

   bwp_sizer #(.LEN_W(LEN_W), .CODE_W(CODE_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)) u_sizer (
      .remaining (remaining),
      .size_code (code_q),
      .pkt_len   (pkt_len),
      .is_last   (is_last)
   );

   bwp_crc16 #(.HAS_CRC(HAS_CRC)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (state == S_TAG && xchg),
      .upd   (state == S_DATA && xchg),
      .din   (src_data),
      .crc   (crc)
   );

   bwp_rsp_scan u_scan (
      .win    (win),
      .status (scan_status)
   );

   always_comb begin
      xfer_req = 1'b0;
      xfer_out = 8'h00;
      unique case (state)
         S_TAG: begin
            xfer_req = 1'b1;
            xfer_out = is_last ? TAG_LAST : (first_q ? TAG_FIRST : TAG_INNER);
         end
         S_DATA: begin
            xfer_req = src_valid;
            xfer_out = src_data;
         end
         S_CRC_HI: begin
            xfer_req = 1'b1;
            xfer_out = crc[15:8];
         end
         S_CRC_LO: begin
            xfer_req = 1'b1;
            xfer_out = crc[7:0];
         end
         S_RSP: xfer_req = 1'b1;
         default: ;
      endcase
   end

   assign xchg      = xfer_req & xfer_ack;
   assign src_ready = (state == S_DATA) && xchg;
   assign done      = (state == S_DONE);
   assign status    = done ? scan_status : ST_OK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         remaining <= '0;
         cnt       <= '0;
         code_q    <= '0;
         first_q   <= 1'b0;
         last_q    <= 1'b0;
         crc_on_q  <= 1'b0;
         widx      <= '0;
         win       <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (start && total_len != '0) begin
               remaining <= total_len;
               code_q    <= size_code;
               crc_on_q  <= crc_en & CRC_BIT;
               first_q   <= 1'b1;
               widx      <= '0;
               state     <= S_TAG;
            end
            S_TAG: if (xchg) begin
               cnt     <= pkt_len;
               last_q  <= is_last;
               first_q <= 1'b0;
               state   <= S_DATA;
            end
            S_DATA: if (xchg) begin
               cnt       <= cnt - LEN_W'(1);
               remaining <= remaining - LEN_W'(1);
               if (cnt == LEN_W'(1))
                  state <= crc_on_q ? S_CRC_HI : (last_q ? S_RSP : S_TAG);
            end
            S_CRC_HI: if (xchg) state <= S_CRC_LO;
            S_CRC_LO: if (xchg) state <= last_q ? S_RSP : S_TAG;
            S_RSP: if (xchg) begin
               win[widx] <= xfer_in;
               widx      <= widx + WIDX_W'(1);
               if (widx == WIDX_W'(RSP_WIN - 1)) state <= S_DONE;
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   // R2: bytes left in the packet never exceed bytes left in the block
   a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DATA) |-> (cnt != '0 && cnt <= remaining));

   // R3: every tag byte carries the 0xF upper nibble
   a_r3_tag_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_TAG && xfer_req) |-> (xfer_out[7:4] == 4'hF));

   // R6: a payload byte is consumed only together with a link exchange
   a_r6_ready_with_xchg: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> (src_valid && xfer_req && xfer_ack));

   // R5: a pending non-payload exchange holds its byte until acknowledged
   a_r5_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack && state != S_DATA) |=> (xfer_req && $stable(xfer_out)));

   // R10: done lasts one cycle and reports a defined status
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_status_known: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != 2'd3));

   // R7: done follows a complete window of four exchanges
   a_r7_window_full: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(state) == S_RSP && widx == '0));
endmodule

// File: tb/sim_bwp_block_writer.sv
`timescale 1ns/1ps
module sim_bwp_block_writer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] total_len = '0;
   logic [2:0]  size_code = '0;
   logic        crc_en = 1'b0;
   logic [7:0]  src_data = '0;
   logic        src_valid = 1'b0;
   logic        src_ready;
   logic        xfer_req;
   logic [7:0]  xfer_out;
   logic        xfer_ack = 1'b0;
   logic [7:0]  xfer_in = '0;
   logic        done;
   logic [1:0]  status;

   always #5 clk = ~clk;

   bwp_block_writer u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
      .size_code(size_code), .crc_en(crc_en), .src_data(src_data),
      .src_valid(src_valid), .src_ready(src_ready), .xfer_req(xfer_req),
      .xfer_out(xfer_out), .xfer_ack(xfer_ack), .xfer_in(xfer_in),
      .done(done), .status(status)
   );

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   int pidx = 0, plen = 0, xidx = 0, flen = 0;
   bit run_on = 0, stall = 0, slow = 0, took = 0;
   logic [7:0] pay [0:1023];
   logic [7:0] lg  [0:2047];
   logic [7:0] ex  [0:2047];
   logic [7:0] rsp [0:3];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v,
                        input string what);
      nchk++;
      if (act !== exp_v) begin
         nfail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
      end
   endtask

   function automatic logic [15:0] ref_crc(input int base, input int n);
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < n; k++) begin
         c = c ^ {pay[base + k], 8'h00};
         for (int b = 0; b < 8; b++)
            c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
      return c;
   endfunction

   task automatic build(input int len, input int code, input bit crc);
      int psz = 1 << (8 + ((code > 5) ? 5 : code));
      int pos = 0, o = 0;
      logic [15:0] c;
      while (pos < len) begin
         int n = ((len - pos) > psz) ? psz : (len - pos);
         bit last = (pos + n == len);
         ex[o] = last ? 8'hF3 : ((pos == 0) ? 8'hF1 : 8'hF2);
         o++;
         for (int k = 0; k < n; k++) begin ex[o] = pay[pos + k]; o++; end
         if (crc) begin
            c = ref_crc(pos, n);
            ex[o] = c[15:8]; ex[o + 1] = c[7:0]; o += 2;
         end
         pos += n;
      end
      for (int k = 0; k < 4; k++) begin ex[o] = 8'h00; o++; end
      flen = o - 4;
   endtask

   // link and source model
   initial forever begin
      @(negedge clk);
      cyc++;
      if (!src_valid || took)
         src_valid = run_on && (pidx < plen) && (!stall || (cyc % 3) != 0);
      took = 0;
      src_data = pay[pidx % 1024];
      #1;
      xfer_in  = (xidx >= flen && xidx < flen + 4) ? rsp[xidx - flen] : 8'hC1;
      xfer_ack = xfer_req && (!slow || (cyc % 2) == 0);
      #1;
      if (xfer_req && xfer_ack) begin
         if (xidx < 2048) lg[xidx] = xfer_out;
         xidx++;
      end
      if (src_valid && src_ready) begin pidx++; took = 1; end
   end

   task automatic run_case(input string req, input int len, input int code, input bit crc,
                           input bit st, input bit sl, input logic [31:0] win,
                           input logic [1:0] exp_st);
      int bad = 0, first_bad = -1;
      bit seen = 0;
      for (int k = 0; k < 1024; k++) pay[k] = 8'(k * 37 + len);
      for (int k = 0; k < 4; k++) rsp[k] = win[31 - 8*k -: 8];
      build(len, code, crc);
      @(negedge clk);
      pidx = 0; xidx = 0; plen = len; stall = st; slow = sl; run_on = 1;
      total_len = 16'(len); size_code = 3'(code); crc_en = crc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int w = 0; w < 40000 && !seen; w++) begin
         @(negedge clk);
         if (done) seen = 1;
      end
      check("R10", 32'(seen), 1, "done seen");
      check(req, 32'(status), 32'(exp_st), "status");
      check("R5", 32'(xidx), 32'(flen + 4), "exchange count");
      for (int k = 0; k < flen + 4 && k < 2048; k++)
         if (lg[k] !== ex[k]) begin bad++; if (first_bad < 0) first_bad = k; end
      if (first_bad >= 0)
         check("R2/R3/R4", 32'(lg[first_bad]), 32'(ex[first_bad]),
               $sformatf("stream byte %0d", first_bad));
      else
         check("R2/R3/R4", 32'(bad), 0, "stream mismatches");
      @(negedge clk);
      check("R10", 32'(done), 0, "done one cycle");
      run_on = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1", 32'(done), 0, "done after reset");
      check("R1", 32'(xfer_req), 0, "xfer_req after reset");
      check("R1", 32'(src_ready), 0, "src_ready after reset");
   endtask

   task automatic t_zero_len();
      @(negedge clk);
      xidx = 0; total_len = 16'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      begin
         bit any_done = 0;
         repeat (20) begin @(negedge clk); if (done) any_done = 1; end
         check("R10", 32'(any_done), 0, "zero length done");
         check("R10", 32'(xidx), 0, "zero length exchanges");
      end
   endtask

   initial begin
      #1500000;
      nfail++;
      $display("FAIL R10 watchdog expired: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R3 single short packet tagged last, R8 ok at index 2
      run_case("R8", 100, 0, 0, 0, 0, 32'h0000C300, 2'd0);
      // R2 R4 three packets with CRC, R7 stale reply before final one
      run_case("R7", 600, 0, 1, 0, 0, 32'hC200C300, 2'd0);
      // R3 exact fit to one packet, ack found at index 0
      run_case("R7", 256, 0, 0, 0, 0, 32'hC3000000, 2'd0);
      // R6 source and link stalls, size code 1
      run_case("R6", 513, 1, 1, 1, 1, 32'h0000C300, 2'd0);
      // R8 last tag at index 2 has wrong type
      run_case("R8", 40, 0, 0, 0, 0, 32'hC300C100, 2'd2);
      // R8 byte after ack not zero
      run_case("R8", 40, 0, 1, 0, 0, 32'h00C30700, 2'd2);
      // R9 start nibble only at index 3
      run_case("R9", 30, 0, 0, 0, 0, 32'h000000C3, 2'd1);
      // R9 0xF tag is not an ack start
      run_case("R9", 30, 0, 0, 1, 0, 32'hF3F300F3, 2'd1);
      // R2 code above range clamps to 8192: one packet
      run_case("R2", 300, 7, 0, 0, 0, 32'h0000C300, 2'd0);
      t_zero_len();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule